// File: doc/BRIEF.md
# Two-Wire EEPROM Slave Protocol Engine

This block is the bus-facing controller of a 4096-byte serial EEPROM. It samples the serial clock and data lines with the system clock. It recognises bus Start and Stop events and decodes the selection byte against three strap inputs. It collects a 12-bit word address, accepts write data and streams read data back. The SDA output is open-drain: the block drives only an enable, and asserting that enable pulls the line low. The memory array, the page buffer and the word-address counter are outside the block. The engine reaches them through single-cycle strobes: an address load, a data write, a commit at Stop, and a read advance. It reads the byte at the current pointer from a data input.

The external programming logic raises a busy input while an internal write cycle runs. During that time the engine leaves its own selection byte unacknowledged, so a host can poll for completion. A Start seen at any point abandons whatever transfer is in progress.

The state machine has eleven states:
- ST_IDLE waits for a Start.
- ST_DEVSEL collects the selection byte. If the byte matches and the device is not busy, it moves to ST_DEV_ACK. Otherwise it returns to ST_IDLE.
- ST_DEV_ACK goes to ST_RD_BYTE when R/W is 1, or to ST_ADR_HI when R/W is 0.
- ST_ADR_HI goes to ST_HI_ACK, then to ST_ADR_LO, then to ST_LO_ACK, then to ST_WR_BYTE.
- ST_WR_BYTE and ST_WR_ACK alternate for as long as data arrives.
- ST_RD_BYTE goes to ST_RD_CHK. On a master acknowledge, ST_RD_CHK returns to ST_RD_BYTE. On a master NACK, it goes to ST_IDLE.
- A Start from any state enters ST_DEVSEL. A Stop from any state enters ST_IDLE.

Each state moves on the falling edge of SCL that follows the eighth data bit, or that ends the acknowledge clock.

Top module: `eeprom_serial_slave`

## Requirements
- R1: After reset the SDA enable is low and no strobe is pulsed.
- R2: A Start (SDA falling while SCL is high) aborts any transfer, including one stopped mid-byte, and the next byte is taken as a selection byte.
- R3: A selection byte whose bits 7:4 are 1010 and whose bits 3:1 equal strap_i is acknowledged by holding SDA low during the ninth SCL clock. Any other selection byte is not acknowledged, and later bytes are ignored until the next Start.
- R4: While busy_i is high, a matching selection byte is not acknowledged. Once busy_i is low, it is acknowledged again.
- R5: After a write selection, two address bytes are acknowledged. On the second one, addr_load_o pulses with addr_o equal to the low 4 bits of the first byte followed by the second byte. The upper 4 bits of the first byte are ignored.
- R6: Each data byte after the address is acknowledged, and produces one wr_strobe_o pulse carrying that byte on wr_data_o.
- R7: A Stop after at least one data byte produces exactly one commit_o pulse. A transfer that ends in a Start instead produces none.
- R8: A read selection (bit 0 = 1) is acknowledged, and the byte on rd_data_i is then sent MSB first. The SDA enable changes only while SCL is low, and rd_next_o pulses once after each byte is sent.
- R9: A master acknowledge after a read byte starts the next byte. A master NACK releases SDA and no further data is driven.
- R10: A write selection with a two-byte address, followed by a repeated Start with a read selection, returns the byte at that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| strap_i | input | 3 | Device select straps |
| busy_i | input | 1 | Internal write cycle in progress |
| addr_load_o | output | 1 | Load external address counter |
| addr_o | output | 12 | Word address to load |
| wr_strobe_o | output | 1 | One received data byte |
| wr_data_o | output | 8 | Received data byte |
| commit_o | output | 1 | Start programming of buffered data |
| rd_next_o | output | 1 | Advance read pointer |
| rd_data_i | input | 8 | Byte at the current pointer |

## Verification
The bench pokes at the selection decode with a wrong strap value and a wrong fixed nibble. A decoder that compared too few bits would acknowledge one of these, and one that failed to stay silent would acknowledge the following byte. It polls immediately after a commit: an engine that ignored busy_i would acknowledge during programming, and one that latched busy would never acknowledge again. It also breaks transfers with a Start in the middle of a selection byte, and after a data byte. Without the abort, the next selection byte would be misframed, or a commit would fire without a Stop. Finally, a sequential read ends with a NACK, so an engine that kept driving would show up as SDA pulled low after the last byte.

// File: rtl/eep_slave_pkg.sv
`timescale 1ns/1ps
package eep_slave_pkg;
    typedef enum logic [3:0] {
        ST_IDLE, ST_DEVSEL, ST_DEV_ACK, ST_ADR_HI, ST_HI_ACK, ST_ADR_LO,
        ST_LO_ACK, ST_WR_BYTE, ST_WR_ACK, ST_RD_BYTE, ST_RD_CHK
    } slv_state_e;
    localparam logic [3:0] DEV_CODE = 4'b1010;
endpackage

// File: rtl/eep_line_sync.sv
`timescale 1ns/1ps
module eep_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe, sda_pipe;
    logic scl_p, sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_p    <= 1'b1;
            sda_p    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_p    <= scl_pipe[STAGES-1];
            sda_p    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/eep_rx_shift.sv
`timescale 1ns/1ps
module eep_rx_shift #(
    parameter int W  = 8,
    localparam int CW = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          rise,
    input  logic          bit_i,
    output logic [W-1:0]  data_o,
    output logic [CW-1:0] cnt_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_o <= '0;
            cnt_o  <= '0;
        end else if (clr) begin
            cnt_o <= '0;
        end else if (rise) begin
            data_o <= {data_o[W-2:0], bit_i};
            cnt_o  <= cnt_o + CW'(1);
        end
    end
endmodule

// File: rtl/eeprom_serial_slave.sv
`timescale 1ns/1ps
module eeprom_serial_slave
    import eep_slave_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int STRAP_W = 3,
    localparam int BYTE_W = 8,
    localparam int HI_W   = ADDR_W - BYTE_W,
    localparam int CW     = $clog2(BYTE_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic              busy_i,
    output logic              addr_load_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              wr_strobe_o,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic              commit_o,
    output logic              rd_next_o,
    input  logic [BYTE_W-1:0] rd_data_i
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [BYTE_W-1:0] rx_byte, tx_q;
    logic [CW-1:0]     bit_cnt;
    logic [HI_W-1:0]   ahi_q;
    logic              rw_q, mack_q, wr_pend_q, byte_done, dev_hit, rx_clr;
    slv_state_e        st_q, st_d;

    eep_line_sync #(.STAGES(2)) sync_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    eep_rx_shift #(.W(BYTE_W)) rx_i (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr), .rise(scl_rise), .bit_i(sda_s),
        .data_o(rx_byte), .cnt_o(bit_cnt)
    );

    assign byte_done = scl_fall && (bit_cnt == CW'(BYTE_W));
    assign dev_hit   = (rx_byte[7:4] == DEV_CODE) &&
                       (rx_byte[STRAP_W:1] == strap_i) && !busy_i;
    assign rx_clr    = start_det | stop_det | (scl_fall && (st_d != st_q));

    // next-state logic
    always_comb begin
        st_d = st_q;
        if (start_det)     st_d = ST_DEVSEL;
        else if (stop_det) st_d = ST_IDLE;
        else begin
            unique case (st_q)
                ST_IDLE:    ;
                ST_DEVSEL:  if (byte_done) st_d = dev_hit ? ST_DEV_ACK : ST_IDLE;
                ST_DEV_ACK: if (scl_fall)  st_d = rw_q ? ST_RD_BYTE : ST_ADR_HI;
                ST_ADR_HI:  if (byte_done) st_d = ST_HI_ACK;
                ST_HI_ACK:  if (scl_fall)  st_d = ST_ADR_LO;
                ST_ADR_LO:  if (byte_done) st_d = ST_LO_ACK;
                ST_LO_ACK:  if (scl_fall)  st_d = ST_WR_BYTE;
                ST_WR_BYTE: if (byte_done) st_d = ST_WR_ACK;
                ST_WR_ACK:  if (scl_fall)  st_d = ST_WR_BYTE;
                ST_RD_BYTE: if (byte_done) st_d = ST_RD_CHK;
                ST_RD_CHK:  if (scl_fall)  st_d = mack_q ? ST_RD_BYTE : ST_IDLE;
                default:    st_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe_o    <= 1'b0;
            addr_load_o <= 1'b0;
            addr_o      <= '0;
            wr_strobe_o <= 1'b0;
            wr_data_o   <= '0;
            commit_o    <= 1'b0;
            rd_next_o   <= 1'b0;
            tx_q        <= '0;
            ahi_q       <= '0;
            rw_q        <= 1'b0;
            mack_q      <= 1'b0;
            wr_pend_q   <= 1'b0;
        end else begin
            addr_load_o <= 1'b0;
            wr_strobe_o <= 1'b0;
            commit_o    <= 1'b0;
            rd_next_o   <= 1'b0;
            if (start_det) begin
                sda_oe_o  <= 1'b0;
                wr_pend_q <= 1'b0;
            end else if (stop_det) begin
                sda_oe_o  <= 1'b0;
                commit_o  <= wr_pend_q;
                wr_pend_q <= 1'b0;
            end else if (scl_rise) begin
                if (st_q == ST_RD_CHK) mack_q <= !sda_s;
            end else if (scl_fall) begin
                unique case (st_d)
                    ST_DEV_ACK, ST_HI_ACK, ST_LO_ACK, ST_WR_ACK: sda_oe_o <= 1'b1;
                    ST_RD_BYTE: begin
                        if (st_q != ST_RD_BYTE) begin
                            tx_q     <= rd_data_i;
                            sda_oe_o <= !rd_data_i[BYTE_W-1];
                        end else begin
                            tx_q     <= {tx_q[BYTE_W-2:0], 1'b0};
                            sda_oe_o <= !tx_q[BYTE_W-2];
                        end
                    end
                    default: sda_oe_o <= 1'b0;
                endcase
                if (st_q == ST_DEVSEL && st_d == ST_DEV_ACK) rw_q <= rx_byte[0];
                if (st_q == ST_ADR_HI && st_d == ST_HI_ACK)  ahi_q <= rx_byte[HI_W-1:0];
                if (st_q == ST_ADR_LO && st_d == ST_LO_ACK) begin
                    addr_load_o <= 1'b1;
                    addr_o      <= {ahi_q, rx_byte};
                end
                if (st_q == ST_WR_BYTE && st_d == ST_WR_ACK) begin
                    wr_strobe_o <= 1'b1;
                    wr_data_o   <= rx_byte;
                    wr_pend_q   <= 1'b1;
                end
                if (st_q == ST_RD_BYTE && st_d == ST_RD_CHK) rd_next_o <= 1'b1;
            end
        end
    end

    // R8: the data line is only moved while the clock line is low
    a_r8_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> !scl_s);
    // R3: the line is pulled only in acknowledge or read-data states
    a_r3_drive_in_legal_state: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe_o |-> (st_q inside {ST_DEV_ACK, ST_HI_ACK, ST_LO_ACK, ST_WR_ACK, ST_RD_BYTE}));
    // R4: no selection acknowledge is granted while programming is busy
    a_r4_no_ack_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DEV_ACK && $past(st_q) == ST_DEVSEL) |-> !$past(busy_i));
    // R7: commit only follows a Stop event
    a_r7_commit_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> $past(stop_det));
    // R6: memory-side strobes never coincide
    a_r6_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({addr_load_o, wr_strobe_o, commit_o, rd_next_o}));
endmodule

// File: tb/eeprom_serial_slave_tb_top.sv
`timescale 1ns/1ps
module eeprom_serial_slave_tb_top;
    localparam int HALF = 20;
    logic clk = 1'b0, rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic sda_oe, addr_load, wr_strobe, commit, rd_next, busy;
    logic [11:0] addr;
    logic [7:0]  wr_data, rd_data;
    logic [2:0]  strap = 3'b101;
    wire  sda_line = m_sda & ~sda_oe;

    logic [7:0]  mem [4096];
    logic [11:0] ptr, last_addr;
    logic [11:0] pa [32];
    logic [7:0]  pd [32];
    logic [7:0]  last_wr;
    int pn, busy_cnt, n_commit, n_rdnext, n_wr;
    int total = 0, bad = 0;

    always #5 clk = ~clk;

    eeprom_serial_slave dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
        .strap_i(strap), .busy_i(busy), .addr_load_o(addr_load), .addr_o(addr),
        .wr_strobe_o(wr_strobe), .wr_data_o(wr_data), .commit_o(commit),
        .rd_next_o(rd_next), .rd_data_i(rd_data)
    );

    // external memory, page buffer and pointer model
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4096; i++) mem[i] = 8'(i) ^ 8'h5A;
            ptr = 0; pn = 0; busy_cnt = 0; n_commit = 0; n_rdnext = 0; n_wr = 0;
            last_addr = 0; last_wr = 0;
        end else begin
            if (busy_cnt != 0) busy_cnt = busy_cnt - 1;
            if (addr_load) begin ptr = addr; last_addr = addr; end
            if (wr_strobe) begin
                if (pn < 32) begin pa[pn] = ptr; pd[pn] = wr_data; pn = pn + 1; end
                ptr = {ptr[11:5], ptr[4:0] + 5'd1};
                last_wr = wr_data; n_wr = n_wr + 1;
            end
            if (commit) begin
                for (int k = 0; k < pn; k++) mem[pa[k]] = pd[k];
                pn = 0; busy_cnt = 1500; n_commit = n_commit + 1;
            end
            if (rd_next) begin ptr = ptr + 12'd1; n_rdnext = n_rdnext + 1; end
        end
    end
    assign busy    = (busy_cnt != 0);
    assign rd_data = mem[ptr];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hp(); repeat (HALF) @(negedge clk); endtask
    task automatic gap(); repeat (4) @(negedge clk); endtask

    task automatic bus_start();
        m_sda = 1'b1; hp(); m_scl = 1'b1; hp(); m_sda = 1'b0; hp(); m_scl = 1'b0; gap();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; hp(); m_scl = 1'b1; hp(); m_sda = 1'b1; hp();
    endtask

    task automatic send_bit(input logic b);
        m_sda = b; hp(); m_scl = 1'b1; hp(); m_scl = 1'b0; gap();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        m_sda = 1'b1; hp(); m_scl = 1'b1; hp();
        ack = !sda_line;
        m_scl = 1'b0; gap();
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            hp(); m_scl = 1'b1; repeat (HALF/2) @(negedge clk);
            b[i] = sda_line; repeat (HALF/2) @(negedge clk); m_scl = 1'b0; gap();
        end
        m_sda = !mack; hp(); m_scl = 1'b1; hp(); m_scl = 1'b0; gap(); m_sda = 1'b1;
    endtask

    task automatic wait_idle(); repeat (2000) @(negedge clk); endtask

    task automatic t_reset();
        chk("R1 sda_oe after reset", sda_oe, 0);
        chk("R1 no strobes after reset", {addr_load, wr_strobe, commit, rd_next}, 0);
    endtask

    task automatic t_bad_select();
        logic a;
        bus_start(); send_byte(8'hA6, a); chk("R3 wrong strap no ack", a, 0);
        send_byte(8'h00, a);              chk("R3 ignored after mismatch", a, 0);
        bus_start(); send_byte(8'h5A, a); chk("R3 wrong nibble no ack", a, 0);
        bus_stop();
    endtask

    task automatic t_byte_write_poll();
        logic a; int c0;
        c0 = n_commit;
        bus_start(); send_byte(8'hAA, a); chk("R3 matching select ack", a, 1);
        send_byte(8'hF1, a); chk("R5 high address ack", a, 1);
        send_byte(8'h23, a); chk("R5 low address ack", a, 1);
        chk("R5 address upper bits ignored", last_addr, 12'h123);
        send_byte(8'h3C, a); chk("R6 data ack", a, 1);
        chk("R6 data byte strobed", last_wr, 8'h3C);
        bus_stop(); gap();
        chk("R7 one commit at stop", n_commit - c0, 1);
        bus_start(); send_byte(8'hAA, a); chk("R4 no ack while busy", a, 0);
        bus_stop(); wait_idle();
        bus_start(); send_byte(8'hAA, a); chk("R4 ack after busy ends", a, 1);
        bus_stop();
    endtask

    task automatic t_random_read();
        logic a; logic [7:0] d; int r0;
        r0 = n_rdnext;
        bus_start(); send_byte(8'hAA, a); send_byte(8'h01, a); send_byte(8'h23, a);
        bus_start(); send_byte(8'hAB, a); chk("R8 read select ack", a, 1);
        recv_byte(1'b0, d); chk("R10 random read data", d, 8'h3C);
        bus_stop(); gap();
        chk("R8 one advance per byte", n_rdnext - r0, 1);
    endtask

    task automatic t_page_seq();
        logic a; logic [7:0] d; int lows, w0;
        w0 = n_wr;
        bus_start(); send_byte(8'hAA, a); send_byte(8'h02, a); send_byte(8'h00, a);
        send_byte(8'h11, a); send_byte(8'h22, a); send_byte(8'h33, a);
        chk("R6 three data strobes", n_wr - w0, 3);
        bus_stop(); wait_idle();
        bus_start(); send_byte(8'hAA, a); send_byte(8'h02, a); send_byte(8'h00, a);
        bus_start(); send_byte(8'hAB, a);
        recv_byte(1'b1, d); chk("R9 seq byte 0", d, 8'h11);
        recv_byte(1'b1, d); chk("R9 seq byte 1", d, 8'h22);
        recv_byte(1'b0, d); chk("R9 seq byte 2", d, 8'h33);
        lows = 0;
        for (int i = 0; i < 9; i++) begin
            hp(); m_scl = 1'b1; hp(); if (!sda_line) lows++; m_scl = 1'b0; gap();
        end
        chk("R9 bus released after nack", lows, 0);
        bus_stop();
    endtask

    task automatic t_current_read();
        logic a; logic [7:0] d;
        bus_start(); send_byte(8'hAB, a); chk("R8 current read ack", a, 1);
        recv_byte(1'b0, d); chk("R8 current read data msb first", d, 8'h59);
        bus_stop();
    endtask

    task automatic t_start_mid_byte();
        logic a; logic [7:0] d;
        bus_start(); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        bus_start(); send_byte(8'hAB, a); chk("R2 start mid byte reframes", a, 1);
        recv_byte(1'b0, d); bus_stop();
    endtask

    task automatic t_abort_write();
        logic a; logic [7:0] d; int c0;
        c0 = n_commit;
        bus_start(); send_byte(8'hAA, a); send_byte(8'h04, a); send_byte(8'h00, a);
        send_byte(8'h99, a);
        bus_start(); send_byte(8'hAA, a); chk("R2 select after abort", a, 1);
        send_byte(8'h04, a); send_byte(8'h00, a);
        bus_start(); send_byte(8'hAB, a); recv_byte(1'b0, d); bus_stop(); gap();
        chk("R7 no commit after start abort", n_commit - c0, 0);
        chk("R2 aborted data not written", d, 8'h5A);
    endtask

    initial begin
        repeat (10) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        t_reset();
        t_bad_select();
        t_byte_write_poll();
        wait_idle();
        t_random_read();
        t_page_seq();
        t_current_read();
        t_start_mid_byte();
        t_abort_write();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule